// File: doc/BRIEF.md
# Load-Instruction Byte Decoder with Prefix Tracking

This block takes the instruction stream of an 8-bit CPU one byte at a time and recognises the family of load (move) instructions. It accepts a byte whenever `in_valid` and `in_ready` are both high. It tracks two kinds of prefix byte. The first kind swaps the HL pointer for one of two index registers. The second opens an extended opcode page. After the opcode, the block gathers any signed displacement byte and any immediate or address bytes.

Once the last byte of an instruction has arrived, the block presents a single decoded record and raises `out_valid` for one cycle. The record gives an operation width class, destination and source selectors, the index register in use, the displacement and a 16-bit operand word. It also carries flags for HALT, an invalid prefixed form, a non-load opcode and flag-affecting transfers. Executing the instruction is left to downstream logic.

Selector codes used in `out_dst`/`out_src` for 8-bit transfers (`out_kind`=1): 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory at HL (or at index+displacement when `out_idx`≠0), 7 A, 8 index high byte, 9 index low byte, 10 memory at BC, 11 memory at DE, 12 memory at the 16-bit address in `out_word`, 13 I, 14 R, 15 immediate in `out_word`. For 16-bit transfers (`out_kind`=2): 0 BC, 1 DE, 2 HL, 3 SP, 4 the selected index register, 12 memory at `out_word`, 15 immediate in `out_word`. When the record is HALT, invalid or not a load, `out_kind` is 0 and both selectors are 15.

Top module: `ld_byte_decoder`

## Requirements
- R1: A plain opcode 01 ddd sss (with neither field 110) yields kind 1, `out_dst`=ddd, `out_src`=sss, using register codes 000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 111 A.
- R2: Field value 110 in a plain 01 ddd sss opcode selects code 6 (memory at HL). The opcode 0x76 yields `out_halt`=1, kind 0, and is not a load.
- R3: Opcode 00 rrr 110 takes one further byte and yields kind 1, dst=rrr (6 when rrr=110), src 15, `out_word`={8'h00, byte}.
- R4: Opcode 00 m p t 010 gives the following transfers. With m=0 it moves A to or from memory at BC (p=0, code 10) or DE (p=1, code 11). With m=1 it takes a 16-bit address, and p selects A (kind 1) or HL (kind 2). Bit t=1 reads memory into the register and t=0 writes the register to memory.
- R5: Opcode 00 pp 0 001 yields kind 2, dst=pp (00 BC, 01 DE, 10 HL, 11 SP), src 15, with a 16-bit immediate. Opcode 0xF9 yields kind 2, dst 3, src 2.
- R6: Prefix 0xDD sets `out_idx`=1 and 0xFD sets `out_idx`=2. Under a prefix, the HL pair becomes 16-bit code 4. Any code-6 memory operand gains a displacement byte that follows the opcode directly, and that byte is reported in `out_disp`. `out_disp` is 0 whenever no displacement was taken.
- R7: Prefix, 0x36, d, n yields dst 6, src 15, `out_disp`=d, `out_word`=n. The displacement comes before the immediate.
- R8: An index prefix followed by 0x76 yields `out_bad`=1, kind 0 and `out_halt`=0.
- R9: Under an index prefix, in 01 r r' with no 110 field, and in 00 rrr 110 with rrr not 110, codes 100 and 101 become 8 and 9 (index high and low). When a memory operand is present, 100 and 101 stay H and L.
- R10: After prefix 0xED, 01 pp 1 011 yields kind 2, dst=pp, src 12, and 01 pp 0 011 yields dst 12, src=pp. Both take a 16-bit address. 0x47, 0x4F, 0x57 and 0x5F give A→I, A→R, I→A and R→A. `out_flags`=1 only for the last two.
- R11: Two-byte operands arrive low byte first and are reported as one 16-bit `out_word`.
- R12: When several index prefixes come in a row, the last one alone decides `out_idx`.
- R13: After reset `out_valid`=0 and `in_ready`=1. `out_valid` lasts exactly one cycle per instruction and `in_ready` is 0 during that cycle. The record stays unchanged until the next opcode byte is accepted.
- R14: A first non-prefix byte outside the load family produces a record at once, with `out_notld`=1, kind 0 and `out_idx` set to the active index prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte can be accepted |
| out_valid | output | 1 | One-cycle record strobe |
| out_kind | output | 2 | 0 none, 1 eight-bit, 2 sixteen-bit |
| out_dst | output | 4 | Destination selector |
| out_src | output | 4 | Source selector |
| out_idx | output | 2 | 0 none, 1 first index, 2 second index |
| out_disp | output | 8 | Signed displacement |
| out_word | output | 16 | Immediate or address |
| out_halt | output | 1 | HALT opcode seen |
| out_bad | output | 1 | Invalid prefixed form |
| out_notld | output | 1 | Opcode is not a load |
| out_flags | output | 1 | Transfer affects flags |

## Verification
The bench targets the points where prefix state changes how an opcode is read.

- A chain of two index prefixes checks that only the later one counts. A decoder that keeps the first would report the wrong index.
- A prefixed 0x76 must come out invalid rather than HALT.
- H and L must be remapped to index halves only when no memory operand is present. A decoder that remaps them always would turn "load H from indexed memory" into "load index-high".
- The prefixed immediate store has its displacement and immediate in a fixed order. A swap would show up in `out_disp` and `out_word`.
- Byte order of address operands is checked, and so are the duplicate HL encodings on the extended page.
- Every clock, the bench compares the strobe against its expected timing. This exposes a strobe that lasts too long, or bytes taken while a record is pending.

// File: rtl/ld_byte_decoder.sv
module ld_byte_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        out_valid,
  output logic [1:0]  out_kind,
  output logic [3:0]  out_dst,
  output logic [3:0]  out_src,
  output logic [1:0]  out_idx,
  output logic [7:0]  out_disp,
  output logic [15:0] out_word,
  output logic        out_halt,
  output logic        out_bad,
  output logic        out_notld,
  output logic        out_flags
);
  localparam logic [1:0] K_NONE = 2'd0, K_B8 = 2'd1, K_B16 = 2'd2;
  localparam logic [3:0] C_A = 4'd7, C_HLM = 4'd6, C_BCM = 4'd10, C_DEM = 4'd11,
                         C_ABS = 4'd12, C_I = 4'd13, C_R = 4'd14, C_IMM = 4'd15,
                         C_SP = 4'd3, C_HL = 4'd2, C_IDX = 4'd4;

  typedef enum logic [1:0] {S_OP, S_DISP, S_LO, S_HI} st_t;
  st_t st;
  logic [1:0] pfx;
  logic ext, two;

  wire acc = in_valid && in_ready;
  wire [1:0] x = in_byte[7:6];
  wire [2:0] y = in_byte[5:3];
  wire [2:0] z = in_byte[2:0];
  wire is_pre = !ext && (in_byte == 8'hDD || in_byte == 8'hFD || in_byte == 8'hED);
  wire hasp = pfx != 2'd0;

  assign in_ready = !out_valid;

  function automatic logic [3:0] r8(input logic [2:0] r, input logic mem, input logic p);
    if (p && !mem && r[2:1] == 2'b10) return {3'b100, r[0]};
    return {1'b0, r};
  endfunction

  function automatic logic [3:0] r16(input logic [1:0] pp, input logic p);
    if (p && pp == 2'b10) return C_IDX;
    return {2'b00, pp};
  endfunction

  logic [1:0] d_kind, d_n;
  logic [3:0] d_dst, d_src;
  logic d_halt, d_bad, d_notld, d_flags, d_disp;

  always_comb begin
    d_kind = K_NONE; d_dst = C_IMM; d_src = C_IMM; d_n = 2'd0;
    d_halt = 1'b0; d_bad = 1'b0; d_notld = 1'b0; d_flags = 1'b0; d_disp = 1'b0;
    if (ext) begin
      if (x == 2'b01 && z == 3'b011) begin
        d_kind = K_B16; d_n = 2'd2;
        d_dst = in_byte[3] ? r16(in_byte[5:4], 1'b0) : C_ABS;
        d_src = in_byte[3] ? C_ABS : r16(in_byte[5:4], 1'b0);
      end else begin
        d_kind = K_B8;
        case (in_byte)
          8'h47: begin d_dst = C_I; d_src = C_A; end
          8'h4F: begin d_dst = C_R; d_src = C_A; end
          8'h57: begin d_dst = C_A; d_src = C_I; d_flags = 1'b1; end
          8'h5F: begin d_dst = C_A; d_src = C_R; d_flags = 1'b1; end
          default: begin d_kind = K_NONE; d_notld = 1'b1; end
        endcase
      end
    end else if (in_byte == 8'h76) begin
      d_halt = !hasp; d_bad = hasp;
    end else if (x == 2'b01) begin
      d_kind = K_B8;
      d_dst = r8(y, y == 3'd6 || z == 3'd6, hasp);
      d_src = r8(z, y == 3'd6 || z == 3'd6, hasp);
      d_disp = hasp && (y == 3'd6 || z == 3'd6);
    end else if (x == 2'b00 && z == 3'd6) begin
      d_kind = K_B8; d_n = 2'd1;
      d_dst = r8(y, y == 3'd6, hasp);
      d_disp = hasp && y == 3'd6;
    end else if (x == 2'b00 && z == 3'd2) begin
      d_kind = (in_byte[5] && !in_byte[4]) ? K_B16 : K_B8;
      d_n = in_byte[5] ? 2'd2 : 2'd0;
      if (!in_byte[5]) begin
        d_dst = in_byte[3] ? C_A : (in_byte[4] ? C_DEM : C_BCM);
        d_src = in_byte[3] ? (in_byte[4] ? C_DEM : C_BCM) : C_A;
      end else begin
        d_dst = in_byte[3] ? (in_byte[4] ? C_A : r16(2'b10, hasp)) : C_ABS;
        d_src = in_byte[3] ? C_ABS : (in_byte[4] ? C_A : r16(2'b10, hasp));
      end
    end else if (x == 2'b00 && z == 3'd1 && !in_byte[3]) begin
      d_kind = K_B16; d_n = 2'd2;
      d_dst = r16(in_byte[5:4], hasp);
    end else if (in_byte == 8'hF9) begin
      d_kind = K_B16; d_dst = C_SP; d_src = r16(2'b10, hasp);
    end else begin
      d_notld = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OP; pfx <= 2'd0; ext <= 1'b0; two <= 1'b0; out_valid <= 1'b0;
      out_kind <= K_NONE; out_dst <= C_IMM; out_src <= C_IMM; out_idx <= 2'd0;
      out_disp <= 8'h00; out_word <= 16'h0000;
      out_halt <= 1'b0; out_bad <= 1'b0; out_notld <= 1'b0; out_flags <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (acc) begin
        case (st)
          S_OP: begin
            if (is_pre) begin
              if (in_byte == 8'hED) begin ext <= 1'b1; pfx <= 2'd0; end
              else pfx <= in_byte[5] ? 2'd2 : 2'd1;
            end else begin
              out_kind <= d_kind; out_dst <= d_dst; out_src <= d_src; out_idx <= pfx;
              out_halt <= d_halt; out_bad <= d_bad; out_notld <= d_notld; out_flags <= d_flags;
              out_disp <= 8'h00; out_word <= 16'h0000; two <= d_n == 2'd2;
              pfx <= 2'd0; ext <= 1'b0;
              if (d_disp) st <= S_DISP;
              else if (d_n != 2'd0) st <= S_LO;
              else out_valid <= 1'b1;
            end
          end
          S_DISP: begin
            out_disp <= in_byte;
            if (out_dst == C_IMM || out_src == C_IMM) st <= S_LO;
            else begin st <= S_OP; out_valid <= 1'b1; end
          end
          S_LO: begin
            out_word <= {8'h00, in_byte};
            if (two) st <= S_HI;
            else begin st <= S_OP; out_valid <= 1'b1; end
          end
          default: begin
            out_word[15:8] <= in_byte; st <= S_OP; out_valid <= 1'b1;
          end
        endcase
      end
    end
  end

  p_one_cycle_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_hold_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  p_record_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> ($stable(out_word) && $stable(out_dst) && $stable(out_src) && $stable(out_disp)));
  p_strobe_after_byte_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc));
  p_halt_unprefixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_halt) |-> (out_idx == 2'd0 && out_kind == K_NONE && !out_bad));
  p_bad_needs_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bad) |-> (out_idx != 2'd0 && out_kind == K_NONE));
  p_no_disp_unindexed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx == 2'd0) |-> out_disp == 8'h00);
  p_flags_to_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags) |-> (out_kind == K_B8 && out_dst == C_A));
endmodule

// File: tb/sim_ld_byte_decoder.sv
module sim_ld_byte_decoder;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, out_valid, out_halt, out_bad, out_notld, out_flags;
  logic [1:0] out_kind, out_idx;
  logic [3:0] out_dst, out_src;
  logic [7:0] out_disp;
  logic [15:0] out_word;

  always #10 clk = ~clk;

  ld_byte_decoder u0 (.clk, .rst_n, .in_valid, .in_byte, .in_ready, .out_valid,
    .out_kind, .out_dst, .out_src, .out_idx, .out_disp, .out_word,
    .out_halt, .out_bad, .out_notld, .out_flags);

  int tests = 0, fails = 0;
  logic [41:0] expq[$];
  string tagq[$];
  logic exp_pulse = 1'b0;
  logic [41:0] last_rec;
  logic last_valid = 1'b0;
  logic running = 1'b0;

  function automatic logic [41:0] rec(input int k, input int d, input int s, input int ix,
      input int disp, input int w, input bit h, input bit b, input bit nl, input bit f);
    return {k[1:0], d[3:0], s[3:0], ix[1:0], disp[7:0], w[15:0], h, b, nl, f};
  endfunction

  wire [41:0] got = {out_kind, out_dst, out_src, out_idx, out_disp, out_word,
                     out_halt, out_bad, out_notld, out_flags};

  task automatic check(input bit ok, input string tag, input logic [41:0] act, input logic [41:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (running) begin
    check(out_valid === exp_pulse, "R13 strobe timing", {41'd0, out_valid}, {41'd0, exp_pulse});
    if (out_valid) begin
      check(in_ready === 1'b0, "R13 ready low while pending", {41'd0, in_ready}, 42'd0);
      if (expq.size() > 0) begin
        logic [41:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(got === e, t, got, e);
      end
    end else if (last_valid) begin
      check(got === last_rec, "R13 record held", got, last_rec);
    end
    last_valid = out_valid;
    last_rec = got;
    exp_pulse = 1'b0;
  end

  task automatic send(input logic [7:0] b[$], input logic [41:0] e, input string tag);
    foreach (b[i]) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_byte = b[i];
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      if (i == b.size() - 1) begin
        expq.push_back(e);
        tagq.push_back(tag);
        exp_pulse = 1'b1;
      end
    end
  endtask

  initial begin
    #200000000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R13 reset state",
          {40'd0, out_valid, in_ready}, 42'd1);
    running = 1'b1;

    send('{8'h57}, rec(1,2,7,0,0,0,0,0,0,0), "R1 D<-A");
    send('{8'h79}, rec(1,7,1,0,0,0,0,0,0,0), "R1 A<-C");
    send('{8'h4E}, rec(1,1,6,0,0,0,0,0,0,0), "R2 C<-(HL)");
    send('{8'h70}, rec(1,6,0,0,0,0,0,0,0,0), "R2 (HL)<-B");
    send('{8'h76}, rec(0,15,15,0,0,0,1,0,0,0), "R2 halt");
    send('{8'h26, 8'h5A}, rec(1,4,15,0,0,16'h005A,0,0,0,0), "R3 H<-n");
    send('{8'h36, 8'h99}, rec(1,6,15,0,0,16'h0099,0,0,0,0), "R3 (HL)<-n");
    send('{8'h02}, rec(1,10,7,0,0,0,0,0,0,0), "R4 (BC)<-A");
    send('{8'h1A}, rec(1,7,11,0,0,0,0,0,0,0), "R4 A<-(DE)");
    send('{8'h32, 8'h34, 8'h12}, rec(1,12,7,0,0,16'h1234,0,0,0,0), "R4 R11 (nn)<-A");
    send('{8'h2A, 8'h78, 8'h56}, rec(2,2,12,0,0,16'h5678,0,0,0,0), "R4 R11 HL<-(nn)");
    send('{8'h31, 8'hCD, 8'hAB}, rec(2,3,15,0,0,16'hABCD,0,0,0,0), "R5 R11 SP<-nn");
    send('{8'hF9}, rec(2,3,2,0,0,0,0,0,0,0), "R5 SP<-HL");
    send('{8'hDD, 8'h46, 8'hFE}, rec(1,0,6,1,8'hFE,0,0,0,0,0), "R6 B<-(IX-2)");
    send('{8'hFD, 8'h74, 8'h05}, rec(1,6,4,2,8'h05,0,0,0,0,0), "R6 R9 (IY+5)<-H");
    send('{8'hDD, 8'h21, 8'h34, 8'h12}, rec(2,4,15,1,0,16'h1234,0,0,0,0), "R6 IX<-nn");
    send('{8'hFD, 8'hF9}, rec(2,3,4,2,0,0,0,0,0,0), "R6 SP<-IY");
    send('{8'hDD, 8'h22, 8'h00, 8'hC0}, rec(2,12,4,1,0,16'hC000,0,0,0,0), "R6 (nn)<-IX");
    send('{8'hDD, 8'h36, 8'h80, 8'h42}, rec(1,6,15,1,8'h80,16'h0042,0,0,0,0), "R7 (IX-128)<-n");
    send('{8'hFD, 8'h76}, rec(0,15,15,2,0,0,0,1,0,0), "R8 prefixed 76");
    send('{8'hDD, 8'h44}, rec(1,0,8,1,0,0,0,0,0,0), "R9 B<-IXH");
    send('{8'hFD, 8'h6F}, rec(1,9,7,2,0,0,0,0,0,0), "R9 IYL<-A");
    send('{8'hDD, 8'h65}, rec(1,8,9,1,0,0,0,0,0,0), "R9 IXH<-IXL");
    send('{8'hFD, 8'h2E, 8'h11}, rec(1,9,15,2,0,16'h0011,0,0,0,0), "R9 IYL<-n");
    send('{8'hED, 8'h4B, 8'h00, 8'h80}, rec(2,0,12,0,0,16'h8000,0,0,0,0), "R10 BC<-(nn)");
    send('{8'hED, 8'h73, 8'h10, 8'h20}, rec(2,12,3,0,0,16'h2010,0,0,0,0), "R10 (nn)<-SP");
    send('{8'hED, 8'h6B, 8'h01, 8'h02}, rec(2,2,12,0,0,16'h0201,0,0,0,0), "R10 HL<-(nn) alt");
    send('{8'hED, 8'h47}, rec(1,13,7,0,0,0,0,0,0,0), "R10 I<-A");
    send('{8'hED, 8'h4F}, rec(1,14,7,0,0,0,0,0,0,0), "R10 R<-A");
    send('{8'hED, 8'h57}, rec(1,7,13,0,0,0,0,0,0,1), "R10 A<-I flags");
    send('{8'hED, 8'h5F}, rec(1,7,14,0,0,0,0,0,0,1), "R10 A<-R flags");
    send('{8'hDD, 8'hFD, 8'h7E, 8'h03}, rec(1,7,6,2,8'h03,0,0,0,0,0), "R12 last prefix IY");
    send('{8'hFD, 8'hDD, 8'h66, 8'h7F}, rec(1,4,6,1,8'h7F,0,0,0,0,0), "R12 last prefix IX");
    send('{8'hC3}, rec(0,15,15,0,0,0,0,0,1,0), "R14 jump");
    send('{8'hDD, 8'h80}, rec(0,15,15,1,0,0,0,0,1,0), "R14 prefixed add");
    send('{8'hED, 8'h44}, rec(0,15,15,0,0,0,0,0,1,0), "R14 extended non-load");
    send('{8'h78}, rec(1,7,0,0,0,0,0,0,0,0), "R1 A<-B after prefixes cleared");

    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R13 all records seen", 42'(expq.size()), 42'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule